// File: doc/BRIEF.md
# Test Status and Inactivity Monitor

This block watches a memory-traffic test from the side. While a test runs it counts clock cycles, issued read and write requests and successful compare-exchange operations. It gathers the error flags raised by the traffic sequencer and measures two overheads: the time before the first request and the time after the last one. A consecutive-idle watchdog with a programmable threshold catches a stalled test.

A test ends in one of three ways: the sequencer reports normal completion, software forces it to end, or an error is seen (a sequencer error flag or an inactivity timeout). The block then emits one 512-bit status record, its target address and a one-cycle write strobe toward the memory write path. Each record carries a rolling identifier, so the reader can tell a fresh record from a stale one. At the same moment it can raise an interrupt request, either at the end of every test or only when the test ended with errors.

Top module: `test_status_monitor`

## Requirements
- R1: A test becomes active on the cycle after `start_i` is seen while no test is active; `start_i` during an active test is ignored. Record bits [127:64] hold the number of active cycles, counting the finishing cycle.
- R2: In active cycles only, `rd_req_i`, `wr_req_i` and `cas_ok_i` are counted into record bits [159:128], [191:160] and [31:16] respectively.
- R3: The idle count advances on each active cycle with none of `rd_req_i`, `wr_req_i`, `rsp_i` high and clears on any of them. When it reaches a nonzero `thresh_i`, that cycle is a timeout and `timeout_o` is high from the next cycle until the next accepted start. `thresh_i` of 0 disables the timeout.
- R4: A timeout is an error: it sets record bit 63 and ends the test in the same cycle.
- R5: A test finishes in the first active cycle with `done_i`, `force_i`, any `err_i` bit, or a timeout. `stat_wr_o` is high for exactly one cycle, the cycle after it. `force_i` or `done_i` while no test is active does nothing.
- R6: `err_i` bits seen in active cycles are ORed into record bits [32+ERR_W-1:32].
- R7: Record bit 0 is 1. Bits [15:1] hold an identifier that is 0 after reset, grows by one on every status write (the first write carries 1) and wraps modulo 2^15.
- R8: `irq_o` pulses together with `stat_wr_o` when `irq_end_en_i` is set, or when `irq_err_en_i` is set and record bits [63:32] are nonzero.
- R9: Bits [223:192] count active cycles before the first cycle with a read or write request. Bits [255:224] count active cycles since the last such cycle, or since the start when there was none.
- R10: Bits [511:256] take `err_dump_i` and `stat_addr_o` takes `base_addr_i + STAT_OFS`, both sampled in the finishing cycle. Between writes the record and address hold their values.
- R11: After reset, `stat_line_o`, `stat_addr_o`, `stat_wr_o`, `timeout_o` and `irq_o` are zero.
- R12: A forced finish leaves a record identical in bits [255:16] to a normal finish under the same traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| force_i | input | 1 | Force-finish pulse |
| done_i | input | 1 | Normal completion from sequencer |
| rd_req_i | input | 1 | Read request issued |
| wr_req_i | input | 1 | Write request issued |
| rsp_i | input | 1 | Response received |
| cas_ok_i | input | 1 | Compare-exchange succeeded |
| err_i | input | ERR_W | Sequencer error flags |
| err_dump_i | input | 256 | Error dump from the test mode |
| thresh_i | input | THR_W | Inactivity threshold, 0 disables |
| irq_end_en_i | input | 1 | Interrupt at every test end |
| irq_err_en_i | input | 1 | Interrupt when the test ended with errors |
| base_addr_i | input | ADDR_W | Status area base address |
| stat_line_o | output | 512 | Status record |
| stat_addr_o | output | ADDR_W | Status record address |
| stat_wr_o | output | 1 | Status write strobe |
| timeout_o | output | 1 | Inactivity timeout seen |
| irq_o | output | 1 | Interrupt request |

## Verification
The delicate overlap is an inactivity timeout that matures in the same cycle as a normal completion, or as a sequencer error flag. The bench provokes it with a threshold of three: one read, then three idle cycles, with `done_i` raised on the third. A behavioural model run every clock expects a single status write with bit 63 and `timeout_o` both set, and an interrupt taken through the error path. A second overlap, a start pulse arriving inside a running test, is judged by the clock count not restarting.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  localparam int LINE_W = 512;
  localparam int DUMP_W = 256;
  localparam int CNT_W  = 32;
  localparam int CLK_W  = 64;
  localparam int CAS_W  = 16;
  localparam int UID_W  = 15;
  localparam int EREG_W = 32;

  typedef struct packed {
    logic [DUMP_W-1:0] dump;
    logic [CNT_W-1:0]  end_ovh;
    logic [CNT_W-1:0]  start_ovh;
    logic [CNT_W-1:0]  n_wr;
    logic [CNT_W-1:0]  n_rd;
    logic [CLK_W-1:0]  n_clk;
    logic [EREG_W-1:0] err;
    logic [CAS_W-1:0]  n_cas;
    logic [UID_W-1:0]  uid;
    logic              done;
  } stat_rec_t;
endpackage

// File: rtl/tsm_counter.sv
module tsm_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic         inc,
  output logic [W-1:0] cnt_d
);
  logic [W-1:0] cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)             cnt_d = '0;
    else if (run && inc) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tsm_idle_watch.sv
module tsm_idle_watch #(
  parameter int THR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             activity,
  input  logic [THR_W-1:0] thresh,
  output logic             hit
);
  localparam logic [THR_W-1:0] IDLE_MAX = {THR_W{1'b1}};

  logic [THR_W-1:0] idle_q, idle_d;

  always_comb begin
    idle_d = idle_q;
    if (clr) begin
      idle_d = '0;
    end else if (run) begin
      if (activity)              idle_d = '0;
      else if (idle_q != IDLE_MAX) idle_d = idle_q + THR_W'(1);
    end
    hit = run && (thresh != '0) && (idle_d >= thresh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= '0;
    else        idle_q <= idle_d;
  end
endmodule

// File: rtl/tsm_overhead.sv
module tsm_overhead #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic         req,
  output logic [W-1:0] start_ovh_d,
  output logic [W-1:0] end_ovh_d
);
  logic         seen_q, seen_d;
  logic [W-1:0] sovh_q, eovh_q;

  always_comb begin
    seen_d      = seen_q;
    start_ovh_d = sovh_q;
    end_ovh_d   = eovh_q;
    if (clr) begin
      seen_d      = 1'b0;
      start_ovh_d = '0;
      end_ovh_d   = '0;
    end else if (run) begin
      if (req) begin
        seen_d    = 1'b1;
        end_ovh_d = '0;
      end else begin
        end_ovh_d = eovh_q + W'(1);
        if (!seen_q) start_ovh_d = sovh_q + W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      sovh_q <= '0;
      eovh_q <= '0;
    end else begin
      seen_q <= seen_d;
      sovh_q <= start_ovh_d;
      eovh_q <= end_ovh_d;
    end
  end
endmodule

// File: rtl/tsm_record.sv
module tsm_record
  import tsm_pkg::*;
#(
  parameter int              ADDR_W   = 64,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  stat_rec_t         fields,
  input  logic              irq_end_en,
  input  logic              irq_err_en,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [LINE_W-1:0] line_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wr_q,
  output logic              irq_q
);
  logic [UID_W-1:0]  uid_q, uid_d;
  logic [LINE_W-1:0] line_d;
  logic [ADDR_W-1:0] addr_d;
  logic              wr_d, irq_d;
  stat_rec_t         rec;

  always_comb begin
    uid_d  = uid_q;
    line_d = line_q;
    addr_d = addr_q;
    wr_d   = 1'b0;
    irq_d  = 1'b0;
    rec    = fields;
    if (fire) begin
      uid_d    = uid_q + UID_W'(1);
      rec.uid  = uid_d;
      rec.done = 1'b1;
      line_d   = rec;
      addr_d   = base_addr + STAT_OFS;
      wr_d     = 1'b1;
      irq_d    = irq_end_en || (irq_err_en && (fields.err != '0));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uid_q  <= '0;
      line_q <= '0;
      addr_q <= '0;
      wr_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      uid_q  <= uid_d;
      line_q <= line_d;
      addr_q <= addr_d;
      wr_q   <= wr_d;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/test_status_monitor.sv
module test_status_monitor
  import tsm_pkg::*;
#(
  parameter int                ERR_W    = 8,
  parameter int                THR_W    = 32,
  parameter int                ADDR_W   = 64,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              force_i,
  input  logic              done_i,
  input  logic              rd_req_i,
  input  logic              wr_req_i,
  input  logic              rsp_i,
  input  logic              cas_ok_i,
  input  logic [ERR_W-1:0]  err_i,
  input  logic [DUMP_W-1:0] err_dump_i,
  input  logic [THR_W-1:0]  thresh_i,
  input  logic              irq_end_en_i,
  input  logic              irq_err_en_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  output logic [LINE_W-1:0] stat_line_o,
  output logic [ADDR_W-1:0] stat_addr_o,
  output logic              stat_wr_o,
  output logic              timeout_o,
  output logic              irq_o
);
  localparam int TO_BIT = EREG_W - 1;

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic active_q, active_d;
  logic to_q, to_d;
  logic clr, run, hit, finish;
  logic [EREG_W-1:0] err_q, err_d, err_vec;
  logic [CLK_W-1:0]  n_clk;
  logic [CNT_W-1:0]  n_rd, n_wr, sovh, eovh;
  logic [CAS_W-1:0]  n_cas;
  stat_rec_t         fields;

  assign clr = start_i && !active_q;
  assign run = active_q;

  tsm_counter #(.W(CLK_W)) u_clk_cnt (
    .clk(clk), .rst_n(rst_n_s), .clr(clr), .run(run), .inc(1'b1), .cnt_d(n_clk));
  tsm_counter #(.W(CNT_W)) u_rd_cnt (
    .clk(clk), .rst_n(rst_n_s), .clr(clr), .run(run), .inc(rd_req_i), .cnt_d(n_rd));
  tsm_counter #(.W(CNT_W)) u_wr_cnt (
    .clk(clk), .rst_n(rst_n_s), .clr(clr), .run(run), .inc(wr_req_i), .cnt_d(n_wr));
  tsm_counter #(.W(CAS_W)) u_cas_cnt (
    .clk(clk), .rst_n(rst_n_s), .clr(clr), .run(run), .inc(cas_ok_i), .cnt_d(n_cas));

  tsm_idle_watch #(.THR_W(THR_W)) u_idle (
    .clk(clk), .rst_n(rst_n_s), .clr(clr), .run(run),
    .activity(rd_req_i || wr_req_i || rsp_i), .thresh(thresh_i), .hit(hit));

  tsm_overhead #(.W(CNT_W)) u_ovh (
    .clk(clk), .rst_n(rst_n_s), .clr(clr), .run(run),
    .req(rd_req_i || wr_req_i), .start_ovh_d(sovh), .end_ovh_d(eovh));

  always_comb begin
    err_vec              = '0;
    err_vec[ERR_W-1:0]   = err_i;
    err_vec[TO_BIT]      = hit;
    err_d                = err_q;
    if (clr)      err_d = '0;
    else if (run) err_d = err_q | err_vec;

    finish   = run && (done_i || force_i || (err_i != '0) || hit);

    active_d = active_q;
    if (clr)         active_d = 1'b1;
    else if (finish) active_d = 1'b0;

    to_d = to_q;
    if (clr)             to_d = 1'b0;
    else if (run && hit) to_d = 1'b1;

    fields.dump      = err_dump_i;
    fields.end_ovh   = eovh;
    fields.start_ovh = sovh;
    fields.n_wr      = n_wr;
    fields.n_rd      = n_rd;
    fields.n_clk     = n_clk;
    fields.err       = err_d;
    fields.n_cas     = n_cas;
    fields.uid       = '0;
    fields.done      = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      active_q <= 1'b0;
      to_q     <= 1'b0;
      err_q    <= '0;
    end else begin
      active_q <= active_d;
      to_q     <= to_d;
      err_q    <= err_d;
    end
  end

  tsm_record #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS)) u_rec (
    .clk(clk), .rst_n(rst_n_s), .fire(finish), .fields(fields),
    .irq_end_en(irq_end_en_i), .irq_err_en(irq_err_en_i), .base_addr(base_addr_i),
    .line_q(stat_line_o), .addr_q(stat_addr_o), .wr_q(stat_wr_o), .irq_q(irq_o));

  assign timeout_o = to_q;
endmodule

// File: rtl/tsm_checker.sv
module tsm_checker (
  input logic         clk,
  input logic         rst_n,
  input logic [511:0] stat_line_o,
  input logic         stat_wr_o,
  input logic         timeout_o,
  input logic         irq_o
);
  logic [14:0] prev_uid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         prev_uid <= '0;
    else if (stat_wr_o) prev_uid <= stat_line_o[15:1];
  end

  p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_o |=> !stat_wr_o);

  p_irq_with_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> stat_wr_o);

  p_done_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_o |-> stat_line_o[0]);

  p_uid_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_o |-> (stat_line_o[15:1] == 15'(prev_uid + 15'd1)));

  p_timeout_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> (stat_wr_o && stat_line_o[63]));

  p_line_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr_o |-> $stable(stat_line_o));
endmodule

bind test_status_monitor tsm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .stat_line_o(stat_line_o), .stat_wr_o(stat_wr_o),
  .timeout_o(timeout_o), .irq_o(irq_o));

// File: tb/test_status_monitor_bench.sv
`timescale 1ns/1ps
module test_status_monitor_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start = 0, frc = 0, done = 0, rd = 0, wr = 0, rsp = 0, cas = 0;
  logic [7:0]   err = 0;
  logic [255:0] dump = 0;
  logic [31:0]  thresh = 0;
  logic         en_end = 0, en_err = 0;
  logic [63:0]  base = 64'h1000_0000;

  logic [511:0] line;
  logic [63:0]  addr;
  logic         swr, tmo, irq;

  test_status_monitor u_test_status_monitor (
    .clk(clk), .rst_n(rst_n), .start_i(start), .force_i(frc), .done_i(done),
    .rd_req_i(rd), .wr_req_i(wr), .rsp_i(rsp), .cas_ok_i(cas), .err_i(err),
    .err_dump_i(dump), .thresh_i(thresh), .irq_end_en_i(en_end),
    .irq_err_en_i(en_err), .base_addr_i(base), .stat_line_o(line),
    .stat_addr_o(addr), .stat_wr_o(swr), .timeout_o(tmo), .irq_o(irq));

  int checks = 0, fails = 0, cyc = 0, n_writes = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [511:0] a, input logic [511:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, a, e);
    end
  endtask

  // behavioural reference model
  bit          m_act = 0, m_seen = 0, m_to = 0;
  logic [63:0] m_clk = 0;
  logic [31:0] m_rd = 0, m_wr = 0, m_err = 0, m_so = 0, m_eo = 0;
  int unsigned m_idle = 0;
  logic [15:0] m_cas = 0;
  int          m_uid = 0;
  logic [511:0] e_line = 0;
  logic [63:0]  e_addr = 0;
  bit           e_wr = 0, e_irq = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_act = 0; m_to = 0; m_uid = 0; e_line = 0; e_addr = 0; e_wr = 0; e_irq = 0;
    end else begin
      e_wr = 0; e_irq = 0;
      if (m_act) begin
        bit hit;
        m_clk++;
        if (rd) m_rd++;
        if (wr) m_wr++;
        if (cas) m_cas++;
        if (rd || wr || rsp) m_idle = 0; else m_idle++;
        hit = (thresh != 0) && (m_idle >= thresh);
        if (rd || wr) begin m_seen = 1; m_eo = 0; end
        else begin
          m_eo++;
          if (!m_seen) m_so++;
        end
        m_err[7:0] = m_err[7:0] | err;
        if (hit) begin m_err[31] = 1'b1; m_to = 1; end
        if (done || frc || err != 0 || hit) begin
          m_act = 0;
          m_uid = (m_uid + 1) % 32768;
          e_line = {dump, m_eo, m_so, m_wr, m_rd, m_clk, m_err, m_cas, 15'(m_uid), 1'b1};
          e_addr = base + 64'h40;
          e_wr = 1;
          e_irq = en_end || (en_err && m_err != 0);
        end
      end else if (start) begin
        m_act = 1; m_seen = 0; m_to = 0; m_clk = 0; m_rd = 0; m_wr = 0;
        m_cas = 0; m_err = 0; m_so = 0; m_eo = 0; m_idle = 0;
      end
    end
  end

  logic [511:0] last_line = 0;
  always @(negedge clk) begin
    dump <= {8{32'(cyc * 32'h9E37)}};
    if (rst_n && !finished) begin
      chk("R5 stat_wr_o", 512'(swr), 512'(e_wr));
      chk("R3 timeout_o", 512'(tmo), 512'(m_to));
      chk("R8 irq_o", 512'(irq), 512'(e_irq));
      chk("R10 stat_addr_o", 512'(addr), 512'(e_addr));
      if (e_wr || swr) begin
        chk("R7 done flag/uid", 512'(line[15:0]), 512'(e_line[15:0]));
        chk("R2 cas count", 512'(line[31:16]), 512'(e_line[31:16]));
        chk("R6 error register", 512'(line[63:32]), 512'(e_line[63:32]));
        chk("R1 clock count", 512'(line[127:64]), 512'(e_line[127:64]));
        chk("R2 read/write counts", 512'(line[191:128]), 512'(e_line[191:128]));
        chk("R9 overheads", 512'(line[255:192]), 512'(e_line[255:192]));
        chk("R10 error dump", 512'(line[511:256]), 512'(e_line[511:256]));
      end else begin
        chk("R10 line hold", line, e_line);
      end
      if (swr) begin n_writes++; last_line = line; end
    end
  end

  task automatic step(input bit s, input bit r, input bit w, input bit p, input bit c,
                      input bit d, input bit f, input logic [7:0] e);
    start = s; rd = r; wr = w; rsp = p; cas = c; done = d; frc = f; err = e;
    @(negedge clk);
    start = 0; rd = 0; wr = 0; rsp = 0; cas = 0; done = 0; frc = 0; err = 0;
  endtask

  task automatic traffic(input bit use_force);
    step(1,0,0,0,0,0,0,0);
    step(0,0,0,0,0,0,0,0);
    step(0,0,0,0,0,0,0,0);
    step(0,1,0,0,0,0,0,0);
    step(0,0,0,1,0,0,0,0);
    step(0,0,1,0,1,0,0,0);
    step(0,1,1,1,1,0,0,0);
    step(0,0,0,0,0,0,0,0);
    step(0,0,0,0,0,!use_force,use_force,0);
    step(0,0,0,0,0,0,0,0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [511:0] line_a;
    int w0;
    repeat (3) @(negedge clk);
    chk("R11 reset line", line, 0);
    chk("R11 reset flags", 512'({addr, swr, tmo, irq}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // normal finish with end interrupt
    en_end = 1;
    traffic(0);
    line_a = last_line;
    chk("R1 clock count of normal test", 512'(line_a[127:64]), 512'(64'd8));
    // forced finish, same traffic
    traffic(1);
    chk("R12 forced record equals normal", 512'(last_line[255:16]), 512'(line_a[255:16]));
    chk("R7 identifier advances", 512'(last_line[15:1]), 512'(line_a[15:1] + 15'd1));

    // pure timeout, error interrupt only
    en_end = 0; en_err = 1; thresh = 4;
    step(1,0,0,0,0,0,0,0);
    repeat (6) step(0,0,0,0,0,0,0,0);
    chk("R4 timeout sets bit 63", 512'(last_line[63]), 512'(1'b1));
    chk("R3 timeout flag held", 512'(tmo), 512'(1'b1));

    // error flag, no interrupt enables
    en_err = 0; thresh = 0;
    step(1,0,0,0,0,0,0,0);
    step(0,1,0,0,0,0,0,0);
    step(0,0,0,0,0,0,0,8'h05);
    step(0,0,0,0,0,0,0,0);
    chk("R6 error bits captured", 512'(last_line[39:32]), 512'(8'h05));
    chk("R3 start clears timeout", 512'(tmo), 512'(1'b0));

    // timeout maturing in the same cycle as done
    en_err = 1; thresh = 3; w0 = n_writes;
    step(1,0,0,0,0,0,0,0);
    step(0,1,0,0,0,0,0,0);
    step(0,0,0,0,0,0,0,0);
    step(0,0,0,0,0,0,0,0);
    step(0,0,0,0,0,1,0,0);
    step(0,0,0,0,0,0,0,0);
    step(0,0,0,0,0,0,0,0);
    chk("R5 one write for coincident finish", 512'(n_writes - w0), 512'(1));
    chk("R4 coincident timeout flagged", 512'(last_line[63]), 512'(1'b1));

    // force/done while idle, start during active test
    en_err = 0; thresh = 0; w0 = n_writes;
    step(0,0,0,0,0,0,1,0);
    step(0,0,0,0,0,1,0,0);
    step(0,0,0,0,0,0,0,0);
    chk("R5 force while idle ignored", 512'(n_writes - w0), 512'(0));
    step(1,0,0,0,0,0,0,0);
    step(0,0,0,0,0,0,0,0);
    step(1,1,0,0,0,0,0,0);
    step(0,0,0,0,0,1,0,0);
    step(0,0,0,0,0,0,0,0);
    chk("R1 start while active ignored", 512'(last_line[127:64]), 512'(64'd3));
    chk("R9 start overhead", 512'(last_line[223:192]), 512'(32'd1));
    chk("R9 end overhead", 512'(last_line[255:224]), 512'(32'd1));

    // identifier wrap
    repeat (32770) begin
      step(1,0,0,0,0,0,0,0);
      step(0,0,0,0,0,1,0,0);
    end
    step(0,0,0,0,0,0,0,0);
    chk("R7 identifier wraps", 512'(last_line[15:1]), 512'(n_writes % 32768));
    summary();
  end
endmodule